// File: doc/BRIEF.md
# DMA Channel Arm and Bus Arbitration

This block is the control core of a five-channel DMA controller that shares one memory bus with a CPU. Software arms channels through an 8-bit special-function-register port. A set bit in the low field arms a channel, and a cleared bit leaves that channel unchanged. The top bit is a command that cancels the channels selected in the same write. An external transfer engine sends per-channel trigger pulses and completion pulses. The block holds the triggers as pending requests and picks one bus owner per cycle from the CPU and the armed channels.

Each channel has a two-bit priority level. The lowest level always gives way to the CPU. The next level wins against the CPU on every second contested attempt. The two upper levels always win against the CPU. Among channels, a higher level wins over a lower one, and equal levels resolve toward the lower channel number. When a channel completes, its arm bit clears unless it runs in repeat mode. A completion pulse is reported one cycle later.

Top module: `dma_arm_arb`

## Requirements
- R1: Writing the register with bit 7 low sets each arm bit (bits 4:0, bit n for channel n) whose written bit is 1 and leaves every arm bit written as 0 unchanged, visible on the cycle after the write.
- R2: A read returns the five arm bits in bits 4:0 and zeros in bits 7:5, including after bits 6:5 or 7 were written as 1.
- R3: A write with bit 7 high clears, on the next cycle, the arm bit and pending trigger of every channel whose bit 4:0 is 1 in that write, and sets no arm bit.
- R4: A trigger pulse is accepted only for a channel that is armed in that cycle; a trigger on an unarmed channel produces no grant.
- R5: A completion pulse on an armed channel with repeat low clears its arm bit and raises its completion output for exactly one cycle, starting the cycle after the pulse.
- R6: A completion pulse on a channel with repeat high leaves it armed, still raises the completion output, and a new trigger is accepted at once.
- R7: A completion pulse in the same cycle as an abort that selects that channel raises no completion output.
- R8: Among requesting channels, priority code 11 beats 10, which beats 01, which beats 00; equal codes are granted in ascending channel number, one per cycle.
- R9: A channel at priority code 00 is never granted while the CPU requests.
- R10: For a channel at priority code 01 contending with a continuously requesting CPU, the CPU wins the first contested attempt and the channel wins the next one, so the channel is granted at least every second attempt.
- R11: A channel at priority code 10 or 11 is granted ahead of a requesting CPU.
- R12: The grant output (bit n for channel n, bit 5 for the CPU) is registered, has at most one bit set, is zero when nothing requests, and a granted trigger is consumed so that one trigger yields one grant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sfr_wr | input | 1 | Register write strobe |
| sfr_wdata | input | 8 | Write data: bit 7 abort command, bits 4:0 channel select |
| sfr_rdata | output | 8 | Read data: arm bits in 4:0, zeros above |
| chan_prio | input | 10 | Two-bit priority code per channel, channel n in bits 2n+1:2n |
| chan_repeat | input | 5 | Per-channel repeat mode |
| chan_trig | input | 5 | Per-channel trigger pulses |
| chan_done | input | 5 | Per-channel completion pulses from the transfer engine |
| cpu_req | input | 1 | CPU bus request |
| bus_grant | output | 6 | Registered grant: bits 4:0 channels, bit 5 CPU |
| chan_cmpl | output | 5 | Registered completion pulses |

## Verification
On every cycle, the assertions check that the grant has at most one bit set, that a channel is granted only after it held a request, and that the upper priority levels keep the bus away from the CPU. They also check that an abort leaves its selected channels disarmed with no completion pulse, and that a one-shot completion drops the arm bit. The alternation of the guaranteed level, the ordering between levels and channel numbers, the dropping of triggers on unarmed channels, and the removal of pending triggers by an abort depend on sequences over several cycles. Only the directed bench scenarios show these, by watching the grant cycle by cycle.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;
  localparam int PRIO_W = 2;

  typedef enum logic [PRIO_W-1:0] {
    PRIO_LOW  = 2'd0,
    PRIO_GUAR = 2'd1,
    PRIO_HIGH = 2'd2,
    PRIO_TOP  = 2'd3
  } prio_t;
endpackage

// File: rtl/dma_arm_regs.sv
module dma_arm_regs #(
  parameter int NCH   = 5,
  parameter int REG_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sfr_wr,
  input  logic [REG_W-1:0] sfr_wdata,
  output logic [REG_W-1:0] sfr_rdata,
  input  logic [NCH-1:0]   chan_repeat,
  input  logic [NCH-1:0]   chan_trig,
  input  logic [NCH-1:0]   chan_done,
  input  logic [NCH-1:0]   win_chan,
  output logic [NCH-1:0]   req_chan,
  output logic [NCH-1:0]   chan_cmpl
);
  localparam int ABORT_BIT = REG_W - 1;

  logic [NCH-1:0] arm_q, pend_q, cmpl_q;
  logic [NCH-1:0] abort_sel, set_sel;
  logic           abort_cmd;

  assign abort_cmd = sfr_wr && sfr_wdata[ABORT_BIT];
  assign abort_sel = abort_cmd ? sfr_wdata[NCH-1:0] : '0;
  assign set_sel   = (sfr_wr && !sfr_wdata[ABORT_BIT]) ? sfr_wdata[NCH-1:0] : '0;

  for (genvar i = 0; i < NCH; i++) begin : g_chan
    always_ff @(posedge clk) begin
      if (rst) begin
        arm_q[i]  <= 1'b0;
        pend_q[i] <= 1'b0;
        cmpl_q[i] <= 1'b0;
      end else begin
        if (abort_sel[i])                        arm_q[i] <= 1'b0;
        else if (set_sel[i])                     arm_q[i] <= 1'b1;
        else if (chan_done[i] && !chan_repeat[i]) arm_q[i] <= 1'b0;

        if (abort_sel[i])                    pend_q[i] <= 1'b0;
        else if (chan_trig[i] && arm_q[i])   pend_q[i] <= 1'b1;
        else if (win_chan[i])                pend_q[i] <= 1'b0;

        cmpl_q[i] <= chan_done[i] && arm_q[i] && !abort_sel[i];
      end
    end
  end

  assign req_chan  = pend_q & arm_q;
  assign chan_cmpl = cmpl_q;
  assign sfr_rdata = REG_W'(arm_q);

  // R3
  abort_clears_chk: assert property (@(posedge clk) disable iff (rst)
    $past(abort_cmd) |-> ((arm_q & $past(sfr_wdata[NCH-1:0])) == '0));

  // R5
  one_shot_clear_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(sfr_wr) |-> ((arm_q & $past(chan_done & ~chan_repeat)) == '0));

  // R7
  abort_no_cmpl_chk: assert property (@(posedge clk) disable iff (rst)
    $past(abort_cmd) |-> ((chan_cmpl & $past(sfr_wdata[NCH-1:0])) == '0));

  // R2
  rdata_upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
    sfr_rdata[REG_W-1:NCH] == '0);
endmodule

// File: rtl/dma_arb.sv
module dma_arb
  import dma_arb_pkg::*;
#(
  parameter int NCH = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NCH-1:0]    req_chan,
  input  logic [NCH*PRIO_W-1:0] chan_prio,
  input  logic              cpu_req,
  output logic [NCH-1:0]    win_chan,
  output logic [NCH:0]      bus_grant
);
  localparam int IDX_W = (NCH > 1) ? $clog2(NCH) : 1;

  logic             found;
  prio_t            best_lvl;
  logic [IDX_W-1:0] best_idx;
  logic             dma_wins;
  logic             cpu_win;
  logic             guar_owed_q;
  logic [NCH:0]     grant_q;
  logic             hi_req;

  always_comb begin
    found    = 1'b0;
    best_lvl = PRIO_LOW;
    best_idx = '0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (req_chan[i] && (!found || prio_t'(chan_prio[PRIO_W*i +: PRIO_W]) >= best_lvl)) begin
        found    = 1'b1;
        best_lvl = prio_t'(chan_prio[PRIO_W*i +: PRIO_W]);
        best_idx = IDX_W'(i);
      end
    end
  end

  always_comb begin
    if (!found)        dma_wins = 1'b0;
    else if (!cpu_req) dma_wins = 1'b1;
    else begin
      case (best_lvl)
        PRIO_LOW:  dma_wins = 1'b0;
        PRIO_GUAR: dma_wins = guar_owed_q;
        default:   dma_wins = 1'b1;
      endcase
    end
  end

  for (genvar i = 0; i < NCH; i++) begin : g_win
    assign win_chan[i] = dma_wins && (best_idx == IDX_W'(i));
  end
  assign cpu_win = cpu_req && !dma_wins;

  always_ff @(posedge clk) begin
    if (rst) begin
      grant_q     <= '0;
      guar_owed_q <= 1'b0;
    end else begin
      grant_q <= {cpu_win, win_chan};
      if (cpu_req && found && best_lvl == PRIO_GUAR)
        guar_owed_q <= !guar_owed_q;
    end
  end

  assign bus_grant = grant_q;

  always_comb begin
    hi_req = 1'b0;
    for (int i = 0; i < NCH; i++)
      if (req_chan[i] && chan_prio[PRIO_W*i + 1]) hi_req = 1'b1;
  end

  // R12
  grant_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(bus_grant));

  // R12
  grant_had_req_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_grant[NCH-1:0] & ~$past(req_chan)) == '0);

  // R11
  high_beats_cpu_chk: assert property (@(posedge clk) disable iff (rst)
    (cpu_req && hi_req) |=> !bus_grant[NCH]);

  // R12
  idle_no_grant_chk: assert property (@(posedge clk) disable iff (rst)
    (!cpu_req && req_chan == '0) |=> (bus_grant == '0));
endmodule

// File: rtl/dma_arm_arb.sv
module dma_arm_arb
  import dma_arb_pkg::*;
#(
  parameter int NCH   = 5,
  parameter int REG_W = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  sfr_wr,
  input  logic [REG_W-1:0]      sfr_wdata,
  output logic [REG_W-1:0]      sfr_rdata,
  input  logic [NCH*PRIO_W-1:0] chan_prio,
  input  logic [NCH-1:0]        chan_repeat,
  input  logic [NCH-1:0]        chan_trig,
  input  logic [NCH-1:0]        chan_done,
  input  logic                  cpu_req,
  output logic [NCH:0]          bus_grant,
  output logic [NCH-1:0]        chan_cmpl
);
  logic [NCH-1:0] req_chan;
  logic [NCH-1:0] win_chan;

  dma_arm_regs #(.NCH(NCH), .REG_W(REG_W)) u_regs (
    .clk         (clk),
    .rst         (rst),
    .sfr_wr      (sfr_wr),
    .sfr_wdata   (sfr_wdata),
    .sfr_rdata   (sfr_rdata),
    .chan_repeat (chan_repeat),
    .chan_trig   (chan_trig),
    .chan_done   (chan_done),
    .win_chan    (win_chan),
    .req_chan    (req_chan),
    .chan_cmpl   (chan_cmpl)
  );

  dma_arb #(.NCH(NCH)) u_arb (
    .clk       (clk),
    .rst       (rst),
    .req_chan  (req_chan),
    .chan_prio (chan_prio),
    .cpu_req   (cpu_req),
    .win_chan  (win_chan),
    .bus_grant (bus_grant)
  );
endmodule

// File: tb/dma_arm_arb_tb.sv
module dma_arm_arb_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 5;

  logic       clk = 1'b0;
  logic       rst;
  logic       sfr_wr;
  logic [7:0] sfr_wdata;
  logic [7:0] sfr_rdata;
  logic [9:0] chan_prio;
  logic [4:0] chan_repeat, chan_trig, chan_done;
  logic       cpu_req;
  logic [5:0] bus_grant;
  logic [4:0] chan_cmpl;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  localparam logic [5:0] G_CPU = 6'b100000;

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_arm_arb u_dut (
    .clk(clk), .rst(rst), .sfr_wr(sfr_wr), .sfr_wdata(sfr_wdata),
    .sfr_rdata(sfr_rdata), .chan_prio(chan_prio), .chan_repeat(chan_repeat),
    .chan_trig(chan_trig), .chan_done(chan_done), .cpu_req(cpu_req),
    .bus_grant(bus_grant), .chan_cmpl(chan_cmpl)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1; sfr_wr = 0; sfr_wdata = 0; chan_prio = 0;
    chan_repeat = 0; chan_trig = 0; chan_done = 0; cpu_req = 0;
    tick(); tick();
    rst = 1'b0;
    tick();
  endtask

  task automatic reg_write(logic [7:0] d);
    sfr_wr = 1'b1; sfr_wdata = d;
    tick();
    sfr_wr = 1'b0; sfr_wdata = 0;
  endtask

  task automatic pulse_trig(logic [4:0] m);
    chan_trig = m;
    tick();
    chan_trig = 0;
  endtask

  task automatic t_reset_state();
    do_reset();
    check("R2", "reset rdata", 32'(sfr_rdata), 0);
    check("R12", "reset grant", 32'(bus_grant), 0);
    check("R5", "reset cmpl", 32'(chan_cmpl), 0);
  endtask

  task automatic t_arm_write();
    do_reset();
    reg_write(8'h05);
    check("R1", "arm after 05", 32'(sfr_rdata), 32'h05);
    reg_write(8'h02);
    check("R1", "zero bits keep arm", 32'(sfr_rdata), 32'h07);
    reg_write(8'h60);
    check("R2", "unused bits read zero", 32'(sfr_rdata), 32'h07);
  endtask

  task automatic t_abort();
    do_reset();
    reg_write(8'h1F);
    reg_write(8'h85);
    check("R3", "abort selected only", 32'(sfr_rdata), 32'h1A);
    // abort removes a pending trigger held back by the CPU
    do_reset();
    cpu_req = 1;
    reg_write(8'h02);
    pulse_trig(5'h02);
    tick();
    check("R9", "cpu beats low", 32'(bus_grant), 32'(G_CPU));
    reg_write(8'h82);
    check("R3", "abort disarms", 32'(sfr_rdata), 0);
    reg_write(8'h02);
    cpu_req = 0;
    tick(); tick();
    check("R3", "pending dropped by abort", 32'(bus_grant), 0);
  endtask

  task automatic t_unarmed_trig();
    do_reset();
    reg_write(8'h01);
    pulse_trig(5'h08);
    tick();
    check("R4", "unarmed trigger ignored", 32'(bus_grant), 0);
  endtask

  task automatic t_completion();
    do_reset();
    reg_write(8'h04);
    chan_done = 5'h04;
    tick();
    chan_done = 0;
    check("R5", "one-shot disarm", 32'(sfr_rdata), 0);
    check("R5", "cmpl pulse", 32'(chan_cmpl), 32'h04);
    tick();
    check("R5", "cmpl one cycle", 32'(chan_cmpl), 0);
    // repeat mode
    chan_repeat = 5'h04;
    reg_write(8'h04);
    chan_done = 5'h04;
    tick();
    chan_done = 0;
    check("R6", "repeat keeps arm", 32'(sfr_rdata), 32'h04);
    check("R6", "repeat cmpl pulse", 32'(chan_cmpl), 32'h04);
    pulse_trig(5'h04);
    tick();
    check("R6", "retrigger granted", 32'(bus_grant), 32'h04);
    // abort with simultaneous completion
    chan_repeat = 0;
    chan_done = 5'h04;
    reg_write(8'h84);
    chan_done = 0;
    check("R7", "no cmpl on abort", 32'(chan_cmpl), 0);
    check("R7", "aborted disarmed", 32'(sfr_rdata), 0);
  endtask

  task automatic t_priority();
    do_reset();
    chan_repeat = 5'h1F;
    chan_prio = 10'b00_11_00_10_00; // ch3=11, ch1=10
    reg_write(8'h0A);
    pulse_trig(5'h0A);
    tick();
    check("R8", "top level first", 32'(bus_grant), 32'h08);
    tick();
    check("R8", "high next", 32'(bus_grant), 32'h02);
    tick();
    check("R12", "trigger consumed", 32'(bus_grant), 0);
    chan_prio = 10'b10_00_10_00_00; // ch4=10, ch2=10
    reg_write(8'h14);
    pulse_trig(5'h14);
    tick();
    check("R8", "tie lowest index", 32'(bus_grant), 32'h04);
    tick();
    check("R8", "tie next index", 32'(bus_grant), 32'h10);
  endtask

  task automatic t_cpu_conflicts();
    do_reset();
    chan_repeat = 5'h1F;
    cpu_req = 1;
    chan_prio = 10'b00_00_00_00_00;
    reg_write(8'h01);
    pulse_trig(5'h01);
    tick();
    check("R9", "low loses", 32'(bus_grant), 32'(G_CPU));
    tick();
    check("R9", "low still loses", 32'(bus_grant), 32'(G_CPU));
    cpu_req = 0;
    tick();
    check("R9", "low granted when cpu idle", 32'(bus_grant), 32'h01);
    cpu_req = 1;
    chan_prio = 10'b00_00_00_00_10;
    pulse_trig(5'h01);
    tick();
    check("R11", "high beats cpu", 32'(bus_grant), 32'h01);
    chan_prio = 10'b00_00_00_00_11;
    pulse_trig(5'h01);
    tick();
    check("R11", "top beats cpu", 32'(bus_grant), 32'h01);
  endtask

  task automatic t_guaranteed();
    do_reset();
    chan_repeat = 5'h1F;
    chan_prio = 10'b00_00_00_00_01;
    cpu_req = 1;
    reg_write(8'h01);
    pulse_trig(5'h01);
    tick();
    check("R10", "first contest cpu", 32'(bus_grant), 32'(G_CPU));
    tick();
    check("R10", "second contest dma", 32'(bus_grant), 32'h01);
    pulse_trig(5'h01);
    tick();
    check("R10", "third contest cpu", 32'(bus_grant), 32'(G_CPU));
    tick();
    check("R10", "fourth contest dma", 32'(bus_grant), 32'h01);
    tick();
    check("R12", "cpu alone", 32'(bus_grant), 32'(G_CPU));
  endtask

  initial begin
    t_reset_state();
    t_arm_write();
    t_abort();
    t_unarmed_trig();
    t_completion();
    t_priority();
    t_cpu_conflicts();
    t_guaranteed();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule